// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block sits between a processor's single-word load/store port and a plain word-wide memory port. It holds a small data store of 8 sets, each with two lines of 4 bytes. One tag comparator per way searches both ways of the addressed set at once. A read whose word is present answers in one clock. A write whose tag is present updates only the cache and marks the line dirty. Memory sees a modified line only when that line is evicted.

Each line keeps one valid bit per word rather than one per line. A write that misses claims a line without reading memory, and only the written word becomes valid. A later read of a different word in that line misses. The cache then writes back the line's valid words and refills the whole line from memory.

Victims are chosen per set. An empty way is filled first. Otherwise the cache evicts the way that was used less recently. While any memory transaction is in progress, the processor port holds ready low. Memory requests are held until the memory accepts them, and read data may return any number of cycles later.

Top module: `wb2way_cache`

## Requirements
- R1: A byte address splits, from the bottom up, into a byte-in-word bit (bit 0, ignored), a word select (bit 1), a 3-bit set index (bits 4:2) and a tag (bits 31:5). Two blocks with the same index and different tags are held at once, one in each way.
- R2: A read whose tag matches a way and whose word is valid in that way raises cpu_rsp_valid in the cycle after acceptance, with the most recent data written to that address. It causes no memory request.
- R3: A write whose tag matches a way stores the word in that way, marks the word valid and the line dirty, and responds in the cycle after acceptance. It causes no memory request.
- R4: When the chosen victim line is dirty, each of its valid words is written to memory, at word-aligned byte addresses (bit 0 zero), before the line is reused. A clean victim causes no memory write.
- R5: On a miss, an empty way of the set is filled first. If both ways hold data, the way not touched by the most recent hit or fill in that set is evicted.
- R6: A write miss issues no memory read. It allocates the line with only the written word valid. A later read of another word in that line writes back the dirty words, then refills both words of the line from memory.
- R7: cpu_req_ready is low in every cycle in which a memory request is presented. Each accepted processor request produces exactly one cpu_rsp_valid pulse.
- R8: After reset every line is empty and dirty-free. The first access to any address misses, and the outputs are idle (ready high, no response, no memory request).
- R9: A memory request that is not accepted stays presented, with the same address and direction, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request this cycle |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Byte address of the word |
| cpu_req_wdata | input | WORD_W | Write data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse for an accepted request |
| cpu_rsp_rdata | output | WORD_W | Read data, meaningful with cpu_rsp_valid on reads |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_req_addr | output | ADDR_W | Word-aligned byte address |
| mem_req_wdata | output | WORD_W | Data of a memory write |
| mem_rsp_valid | input | 1 | Read data returned from memory |
| mem_rsp_rdata | input | WORD_W | Returned read data |

## Verification
The bench uses the default parameters: 32-bit addresses, 16-bit words, 8 sets and 4-byte lines. That gives two words per line, so per-word validity and the partial-line refill path can be reached from the ports. Three blocks sharing set 3 force thrashing, and the bench counts the memory writes this produces. A write miss into set 7 followed by a read of the neighbouring word exercises the writeback-then-refill order. A memory model with changing acceptance and return latency, plus a random phase over four times the cache's capacity, exercises eviction of dirty, clean and partly valid lines.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int WAYS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_FINISH
  } wbc_state_e;
endpackage

// File: rtl/wbc_tag_match.sv
module wbc_tag_match
  import wbc_pkg::*;
#(
  parameter int TAG_W  = 27,
  parameter int LW     = 2,
  parameter int WSEL_W = 1
)(
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0][LW-1:0]    way_wvalid,
  input  logic [TAG_W-1:0]           req_tag,
  input  logic [WSEL_W-1:0]          req_word,
  output logic [WAYS-1:0]            live,
  output logic [WAYS-1:0]            tag_hit,
  output logic [WAYS-1:0]            word_hit
);
  // one comparator per way, evaluated side by side
  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign live[g]     = |way_wvalid[g];
    assign tag_hit[g]  = live[g] && (way_tag[g] == req_tag);
    assign word_hit[g] = tag_hit[g] && way_wvalid[g][req_word];
  end
endmodule

// File: rtl/wbc_victim_pick.sv
module wbc_victim_pick
  import wbc_pkg::*;
(
  input  logic [WAYS-1:0] tag_hit,
  input  logic [WAYS-1:0] live,
  input  logic            lru,
  output logic            victim
);
  // a matching but partly valid way is refilled in place;
  // otherwise an empty way wins, then the older way
  always_comb begin
    if (tag_hit[0])      victim = 1'b0;
    else if (tag_hit[1]) victim = 1'b1;
    else if (!live[0])   victim = 1'b0;
    else if (!live[1])   victim = 1'b1;
    else                 victim = lru;
  end
endmodule

// File: rtl/wbc_store.sv
module wbc_store
  import wbc_pkg::*;
#(
  parameter int SETS   = 8,
  parameter int LW     = 2,
  parameter int WORD_W = 16,
  parameter int TAG_W  = 27,
  localparam int IDX_W = $clog2(SETS)
)(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [IDX_W-1:0]                   rd_set,
  output logic [WAYS-1:0][TAG_W-1:0]         rd_tag,
  output logic [WAYS-1:0][LW-1:0]            rd_wvalid,
  output logic [WAYS-1:0]                    rd_dirty,
  output logic [WAYS-1:0][LW-1:0][WORD_W-1:0] rd_data,
  output logic                               rd_lru,
  input  logic                               wr_en,
  input  logic                               wr_way,
  input  logic [IDX_W-1:0]                   wr_set,
  input  logic                               wr_tag_en,
  input  logic [TAG_W-1:0]                   wr_tag,
  input  logic [LW-1:0]                      wr_mask,
  input  logic [LW-1:0][WORD_W-1:0]          wr_data,
  input  logic [LW-1:0]                      wr_valid,
  input  logic                               wr_dirty,
  input  logic                               lru_we,
  input  logic                               lru_d
);
  logic [TAG_W-1:0]  tag_q    [WAYS][SETS];
  logic [WORD_W-1:0] data_q   [WAYS][SETS][LW];
  logic [LW-1:0]     wvalid_q [WAYS][SETS];
  logic              dirty_q  [WAYS][SETS];
  logic              lru_q    [SETS];

  // state bits: cleared by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) begin
        for (int s = 0; s < SETS; s++) begin
          wvalid_q[w][s] <= '0;
          dirty_q[w][s]  <= 1'b0;
        end
      end
      for (int s = 0; s < SETS; s++) lru_q[s] <= 1'b0;
    end else begin
      if (wr_en) begin
        wvalid_q[wr_way][wr_set] <= wr_valid;
        dirty_q[wr_way][wr_set]  <= wr_dirty;
      end
      if (lru_we) lru_q[wr_set] <= lru_d;
    end
  end

  // payload: no reset needed, guarded by the valid bits
  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wr_tag_en) tag_q[wr_way][wr_set] <= wr_tag;
      for (int l = 0; l < LW; l++) begin
        if (wr_mask[l]) data_q[wr_way][wr_set][l] <= wr_data[l];
      end
    end
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_rd
    assign rd_tag[g]    = tag_q[g][rd_set];
    assign rd_wvalid[g] = wvalid_q[g][rd_set];
    assign rd_dirty[g]  = dirty_q[g][rd_set];
    for (genvar l = 0; l < LW; l++) begin : g_word
      assign rd_data[g][l] = data_q[g][rd_set][l];
    end
  end
  assign rd_lru = lru_q[rd_set];
endmodule

// File: rtl/wb2way_cache.sv
module wb2way_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 16,
  parameter int SETS       = 8,
  parameter int LINE_BYTES = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [WORD_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [WORD_W-1:0] cpu_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_rdata
);
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int BYTE_OFF   = $clog2(WORD_BYTES);
  localparam int LW         = LINE_BYTES / WORD_BYTES;
  localparam int WSEL_W     = $clog2(LW);
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int IDX_W      = $clog2(SETS);
  localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;

  // ---- address arithmetic ----
  function automatic logic [IDX_W-1:0] f_index(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[OFF_W+IDX_W +: TAG_W];
  endfunction
  function automatic logic [WSEL_W-1:0] f_word(input logic [ADDR_W-1:0] a);
    return a[BYTE_OFF +: WSEL_W];
  endfunction
  function automatic logic [ADDR_W-1:0] f_mem_addr(input logic [TAG_W-1:0] t,
                                                   input logic [IDX_W-1:0] i,
                                                   input logic [WSEL_W-1:0] w);
    return {t, i, w, {BYTE_OFF{1'b0}}};
  endfunction
  function automatic logic [LW-1:0] f_onehot(input logic [WSEL_W-1:0] w);
    return LW'(1) << w;
  endfunction

  // ---- request decode ----
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic [WSEL_W-1:0] req_word;
  logic              unused_byte_bits;
  assign req_idx          = f_index(cpu_req_addr);
  assign req_tag          = f_tag(cpu_req_addr);
  assign req_word         = f_word(cpu_req_addr);
  assign unused_byte_bits = ^cpu_req_addr[BYTE_OFF-1:0];

  // ---- controller state ----
  wbc_state_e                 state_q;
  logic                       lat_we_q;
  logic [TAG_W-1:0]           lat_tag_q;
  logic [IDX_W-1:0]           lat_idx_q;
  logic [WSEL_W-1:0]          lat_word_q;
  logic [WORD_W-1:0]          lat_wdata_q;
  logic                       vic_way_q;
  logic [TAG_W-1:0]           vic_tag_q;
  logic [LW-1:0]              vic_valid_q;
  logic [WSEL_W-1:0]          cnt_q;
  logic [LW-1:0][WORD_W-1:0]  fill_buf_q;
  logic                       rsp_valid_q;
  logic [WORD_W-1:0]          rsp_data_q;

  // ---- store interface ----
  logic [IDX_W-1:0]                     rd_set;
  logic [WAYS-1:0][TAG_W-1:0]           rd_tag;
  logic [WAYS-1:0][LW-1:0]              rd_wvalid;
  logic [WAYS-1:0]                      rd_dirty;
  logic [WAYS-1:0][LW-1:0][WORD_W-1:0]  rd_data;
  logic                                 rd_lru;
  logic                                 wr_en, wr_way, wr_tag_en, wr_dirty;
  logic [IDX_W-1:0]                     wr_set;
  logic [TAG_W-1:0]                     wr_tag;
  logic [LW-1:0]                        wr_mask, wr_valid;
  logic [LW-1:0][WORD_W-1:0]            wr_data;
  logic                                 lru_we, lru_d;

  // ---- named events for the checker ----
  logic [WAYS-1:0] live, tag_hit, word_hit;
  logic            victim_way;
  logic            hit_way;
  logic            accept;
  logic            ev_hit, ev_miss;
  logic            finish;
  logic            wb_live, cnt_last;
  logic            wmiss_busy;

  assign rd_set = (state_q == ST_IDLE) ? req_idx : lat_idx_q;

  wbc_store #(
    .SETS(SETS), .LW(LW), .WORD_W(WORD_W), .TAG_W(TAG_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_set(rd_set), .rd_tag(rd_tag), .rd_wvalid(rd_wvalid),
    .rd_dirty(rd_dirty), .rd_data(rd_data), .rd_lru(rd_lru),
    .wr_en(wr_en), .wr_way(wr_way), .wr_set(wr_set),
    .wr_tag_en(wr_tag_en), .wr_tag(wr_tag), .wr_mask(wr_mask),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_dirty(wr_dirty),
    .lru_we(lru_we), .lru_d(lru_d)
  );

  wbc_tag_match #(
    .TAG_W(TAG_W), .LW(LW), .WSEL_W(WSEL_W)
  ) u_match (
    .way_tag(rd_tag), .way_wvalid(rd_wvalid),
    .req_tag(req_tag), .req_word(req_word),
    .live(live), .tag_hit(tag_hit), .word_hit(word_hit)
  );

  wbc_victim_pick u_victim (
    .tag_hit(tag_hit), .live(live), .lru(rd_lru), .victim(victim_way)
  );

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign hit_way       = tag_hit[1];
  assign ev_hit        = accept && (cpu_req_we ? (|tag_hit) : (|word_hit));
  assign ev_miss       = accept && !ev_hit;
  assign finish        = (state_q == ST_FINISH);
  assign wb_live       = vic_valid_q[cnt_q];
  assign cnt_last      = (cnt_q == WSEL_W'(LW-1));
  assign wmiss_busy    = (state_q != ST_IDLE) && lat_we_q;

  // ---- memory port ----
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = f_mem_addr(lat_tag_q, lat_idx_q, cnt_q);
    mem_req_wdata = rd_data[vic_way_q][cnt_q];
    unique case (state_q)
      ST_WB: begin
        mem_req_valid = wb_live;
        mem_req_we    = 1'b1;
        mem_req_addr  = f_mem_addr(vic_tag_q, lat_idx_q, cnt_q);
      end
      ST_FILL_REQ: mem_req_valid = 1'b1;
      default: ;
    endcase
  end

  // ---- store write selection ----
  always_comb begin
    wr_en     = 1'b0;
    wr_way    = hit_way;
    wr_set    = req_idx;
    wr_tag_en = 1'b0;
    wr_tag    = lat_tag_q;
    wr_mask   = f_onehot(req_word);
    wr_data   = {LW{cpu_req_wdata}};
    wr_valid  = rd_wvalid[hit_way] | f_onehot(req_word);
    wr_dirty  = 1'b1;
    lru_we    = ev_hit;
    lru_d     = ~hit_way;
    if (ev_hit && cpu_req_we) begin
      wr_en = 1'b1;
    end
    if (finish) begin
      wr_en     = 1'b1;
      wr_way    = vic_way_q;
      wr_set    = lat_idx_q;
      wr_tag_en = 1'b1;
      lru_we    = 1'b1;
      lru_d     = ~vic_way_q;
      if (lat_we_q) begin
        wr_mask  = f_onehot(lat_word_q);
        wr_data  = {LW{lat_wdata_q}};
        wr_valid = f_onehot(lat_word_q);
        wr_dirty = 1'b1;
      end else begin
        wr_mask  = '1;
        wr_data  = fill_buf_q;
        wr_valid = '1;
        wr_dirty = 1'b0;
      end
    end
  end

  // ---- controller ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      lat_we_q    <= 1'b0;
      lat_tag_q   <= '0;
      lat_idx_q   <= '0;
      lat_word_q  <= '0;
      lat_wdata_q <= '0;
      vic_way_q   <= 1'b0;
      vic_tag_q   <= '0;
      vic_valid_q <= '0;
      cnt_q       <= '0;
      fill_buf_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (ev_miss) begin
            lat_we_q    <= cpu_req_we;
            lat_tag_q   <= req_tag;
            lat_idx_q   <= req_idx;
            lat_word_q  <= req_word;
            lat_wdata_q <= cpu_req_wdata;
            vic_way_q   <= victim_way;
            vic_tag_q   <= rd_tag[victim_way];
            vic_valid_q <= rd_wvalid[victim_way];
            cnt_q       <= '0;
            if (rd_dirty[victim_way]) state_q <= ST_WB;
            else if (cpu_req_we)      state_q <= ST_FINISH;
            else                      state_q <= ST_FILL_REQ;
          end
        end
        ST_WB: begin
          if (!wb_live || mem_req_ready) begin
            if (cnt_last) begin
              cnt_q   <= '0;
              state_q <= lat_we_q ? ST_FINISH : ST_FILL_REQ;
            end else begin
              cnt_q <= cnt_q + WSEL_W'(1);
            end
          end
        end
        ST_FILL_REQ: begin
          if (mem_req_ready) state_q <= ST_FILL_WAIT;
        end
        ST_FILL_WAIT: begin
          if (mem_rsp_valid) begin
            fill_buf_q[cnt_q] <= mem_rsp_rdata;
            if (cnt_last) begin
              state_q <= ST_FINISH;
            end else begin
              cnt_q   <= cnt_q + WSEL_W'(1);
              state_q <= ST_FILL_REQ;
            end
          end
        end
        ST_FINISH: begin
          cnt_q   <= '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // ---- processor response ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= ev_hit || finish;
      if (ev_hit && !cpu_req_we)      rsp_data_q <= rd_data[hit_way][req_word];
      else if (finish && !lat_we_q)   rsp_data_q <= fill_buf_q[lat_word_q];
    end
  end

  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_rdata = rsp_data_q;
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int ADDR_W = 32
)(
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              ev_hit,
  input logic              ev_miss,
  input logic              wmiss_busy,
  input logic [1:0]        way_tag_hit
);
  // R1: a block lives in at most one way of its set
  assert_single_way_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_tag_hit));

  // R2: a hit answers in the next cycle
  assert_hit_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> cpu_rsp_valid);

  // R3: a hit never reaches the memory port
  assert_hit_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |-> !mem_req_valid);

  // R6: a write miss never fetches
  assert_wmiss_no_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wmiss_busy && mem_req_valid) |-> mem_req_we);

  // R7: processor port stalled during memory traffic
  assert_stall_on_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cpu_req_ready);

  // R7: a miss gives no response in the following cycle
  assert_miss_no_early_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> !cpu_rsp_valid);

  // R9: unaccepted memory request held steady
  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));
endmodule

bind wb2way_cache wbc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .ev_hit(ev_hit), .ev_miss(ev_miss), .wmiss_busy(wmiss_busy),
  .way_tag_hit(tag_hit)
);

// File: tb/wb2way_cache_tb.sv
`timescale 1ns/1ps
module wb2way_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req_valid, cpu_req_ready, cpu_req_we;
  logic [31:0] cpu_req_addr;
  logic [15:0] cpu_req_wdata;
  logic        cpu_rsp_valid;
  logic [15:0] cpu_rsp_rdata;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0] mem_req_addr;
  logic [15:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [15:0] mem_rsp_rdata;

  int vectors = 0;
  int fails   = 0;
  int mem_writes = 0;
  int mem_reads  = 0;
  bit done = 1'b0;

  logic [15:0] backing [int];
  logic [15:0] golden  [int];

  always #4 clk = ~clk;

  wb2way_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  function automatic logic [15:0] init_word(input int a);
    logic [15:0] v;
    v = 16'(a * 3);
    return v ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] gold_rd(input int a);
    int k = a & ~1;
    return golden.exists(k) ? golden[k] : init_word(k);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model with changing latency
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        automatic int lat = $urandom % 3;
        automatic int a;
        automatic bit w;
        automatic logic [15:0] d;
        repeat (lat) @(negedge clk);
        mem_req_ready = 1'b1;
        a = int'(mem_req_addr);
        w = mem_req_we;
        d = mem_req_wdata;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (w) begin
          check("R4 aligned writeback addr", a & 1, 0);
          backing[a] = d;
          mem_writes++;
        end else begin
          repeat ($urandom % 4) @(negedge clk);
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = backing.exists(a) ? backing[a] : init_word(a);
          @(negedge clk);
          mem_rsp_valid = 1'b0;
          mem_reads++;
        end
      end
    end
  end

  // compared on every clock: no processor acceptance during memory traffic
  always @(negedge clk) begin
    if (rst_n && !done && mem_req_valid) check("R7 ready low with mem req", int'(cpu_req_ready), 0);
  end

  task automatic cpu_op(input bit we, input int a, input logic [15:0] wd,
                        output logic [15:0] rd, output int lat);
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_we    = we;
    cpu_req_addr  = 32'(a);
    cpu_req_wdata = wd;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    lat = 1;
    while (!cpu_rsp_valid) begin
      @(negedge clk);
      lat++;
    end
    rd = cpu_rsp_rdata;
    @(negedge clk);
    check("R7 single response pulse", int'(cpu_rsp_valid), 0);
    if (we) golden[a & ~1] = wd;
  endtask

  task automatic rd_expect(input string req, input int a, input int exp_lat,
                           input int exp_w, input int exp_r);
    logic [15:0] d;
    int lat;
    int w0 = mem_writes;
    int r0 = mem_reads;
    cpu_op(1'b0, a, '0, d, lat);
    check({req, " read data"}, int'(d), int'(gold_rd(a)));
    if (exp_lat > 0) check({req, " latency"}, lat, exp_lat);
    if (exp_w >= 0) check({req, " mem writes"}, mem_writes - w0, exp_w);
    if (exp_r >= 0) check({req, " mem reads"}, mem_reads - r0, exp_r);
  endtask

  task automatic wr_expect(input string req, input int a, input logic [15:0] v,
                           input int exp_lat, input int exp_w, input int exp_r);
    logic [15:0] d;
    int lat;
    int w0 = mem_writes;
    int r0 = mem_reads;
    cpu_op(1'b1, a, v, d, lat);
    if (exp_lat > 0) check({req, " latency"}, lat, exp_lat);
    if (exp_w >= 0) check({req, " mem writes"}, mem_writes - w0, exp_w);
    if (exp_r >= 0) check({req, " mem reads"}, mem_reads - r0, exp_r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int w0;
    cpu_req_valid = 1'b0;
    cpu_req_we    = 1'b0;
    cpu_req_addr  = '0;
    cpu_req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: idle after reset
    check("R8 ready after reset", int'(cpu_req_ready), 1);
    check("R8 no rsp after reset", int'(cpu_rsp_valid), 0);
    check("R8 no mem req after reset", int'(mem_req_valid), 0);

    // R8/R4: cold miss on a clean empty set, two-word refill
    rd_expect("R8 cold read", 'h100, 0, 0, 2);
    // R2: hit
    rd_expect("R2 read hit", 'h100, 1, 0, 0);
    // R3: write hit stays in the cache
    wr_expect("R3 write hit", 'h100, 16'h1234, 1, 0, 0);
    rd_expect("R3 read after write hit", 'h100, 1, 0, 0);
    // R1: byte bit ignored
    rd_expect("R1 odd byte address", 'h101, 1, 0, 0);
    // R1/R5: same index, other tag goes to the empty way
    rd_expect("R5 fill empty way", 'h120, 0, 0, 2);
    rd_expect("R1 first block kept", 'h100, 1, 0, 0);
    rd_expect("R1 second block kept", 'h120, 1, 0, 0);
    // R5: LRU order
    rd_expect("R5 touch A", 'h100, 1, 0, 0);
    rd_expect("R5 evict clean LRU", 'h140, 0, 0, 2);
    rd_expect("R5 recent way kept", 'h100, 1, 0, 0);
    rd_expect("R5 evicted block misses", 'h120, 0, 0, 2);

    // R4/R6: thrash set 3 with three blocks, writes only
    w0 = mem_writes;
    for (int rnd = 0; rnd < 3; rnd++) begin
      wr_expect("R6 thrash write X", 'h00C, 16'(16'h1000 + rnd*3 + 0), 0, -1, 0);
      wr_expect("R6 thrash write Y", 'h02C, 16'(16'h1000 + rnd*3 + 1), 0, -1, 0);
      wr_expect("R6 thrash write Z", 'h04C, 16'(16'h1000 + rnd*3 + 2), 0, -1, 0);
    end
    check("R4 thrash writeback count", mem_writes - w0, 7);
    rd_expect("R4 read X evicts dirty Y", 'h00C, 0, 1, 2);

    // R6: partial line from write miss, then read of other word
    wr_expect("R6 write miss alloc", 'h01E, 16'hBEEF, 0, 0, 0);
    rd_expect("R6 other word refills", 'h01C, 0, 1, 2);
    check("R6 written word reached memory", int'(backing.exists('h1E) ? backing['h1E] : 16'h0), int'(16'hBEEF));
    rd_expect("R6 written word after refill", 'h01E, 1, 0, 0);

    // R2/R4: random traffic over four times the capacity
    for (int i = 0; i < 400; i++) begin
      automatic int a = int'($urandom % 256) & ~1;
      if (($urandom % 3) == 0) begin
        wr_expect("R3 random write", a, 16'($urandom), 0, -1, -1);
      end else begin
        rd_expect("R2 random read", a, 0, -1, -1);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule